// File: doc/BRIEF.md
# Indexed Table-Jump Unit

This unit executes the 16-bit indexed jump of a small RISC-V core. Software first programs a table register with the base address of a jump table. When the front end issues one of these instructions, the unit takes an 8-bit index from the instruction, forms the address of the table slot, and reads the slot through a request/response memory port. The word returned becomes the new program counter. A high index selects the linking form, which also writes the return address (issue PC plus 2) to `ra`.

The table register can be written with any value without a fault. A read always shows a legal value. The low 6 bits are a mode field that reads back as zero. The upper bits hold the table base. If the last write carried a non-zero mode, the following table jumps are reserved. Each one ends with an illegal-instruction pulse and makes no memory access. A later write with mode zero makes table jumps legal again.

A four-state machine sequences each jump:
- IDLE to REQ on an issue.
- IDLE to DONE on an issue with a reserved mode.
- REQ to WAIT when the request is accepted.
- WAIT to DONE when the response arrives.
- DONE to IDLE after one cycle.

`busy` is high in every state except IDLE. Issues that arrive while busy are ignored. `XLEN` may be 32 or 64.

Top module: `tbljmp_unit`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `redirect_valid`, `link_we`, `fault` and `illegal` are 0, and `csr_rd_data` reads 0.
- R2: `csr_rd_data` returns the written value with bits 5:0 forced to zero, whatever mode was written.
- R3: After a write whose bits 5:0 are non-zero, a table jump gives `illegal` = 1 in the cycle after issue. It makes no memory request and produces no redirect or link write. A later write with bits 5:0 equal to zero makes table jumps legal again.
- R4: The table index is `issue_insn[9:2]`. All other instruction bits have no effect on the address, the link decision or the target.
- R5: The request address is the read-back register value plus the index shifted left by 2 (XLEN 32) or by 3 (XLEN 64).
- R6: For an index below 32, completion sets `redirect_valid` = 1 with `redirect_pc` equal to the response data, and `link_we` stays 0.
- R7: For an index of 32 or more, completion also sets `link_we` = 1 with `link_data` = issue PC + 2.
- R8: A response with `mem_rsp_err` = 1 gives `fault` = 1 at completion, with neither redirect nor link write.
- R9: The request goes out in the cycle after issue. It stays asserted with a stable address until `mem_req_ready` is high. `busy` is high from the cycle after issue through the completion cycle. Issues seen while busy are ignored.
- R10: `redirect_valid`, `fault` and `illegal` are single-cycle pulses. At most one of them is high in any cycle, and `busy` is 0 in the cycle after any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Write strobe for the table register |
| csr_wr_data | input | XLEN | Write value (bits 5:0 mode, upper bits base) |
| csr_rd_data | output | XLEN | Legalised register value |
| issue_valid | input | 1 | Table-jump instruction presented |
| issue_insn | input | 16 | Instruction word |
| issue_pc | input | XLEN | PC of the instruction |
| busy | output | 1 | Unit occupied, issues ignored |
| mem_req_valid | output | 1 | Table slot read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | XLEN | Table slot address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | XLEN | Table slot contents |
| mem_rsp_err | input | 1 | Read response is an error |
| redirect_valid | output | 1 | Jump to `redirect_pc` |
| redirect_pc | output | XLEN | New program counter |
| link_we | output | 1 | Write `link_data` to ra |
| link_data | output | XLEN | Return address |
| fault | output | 1 | Access-fault pulse |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
A wrong state register shows up within a cycle or two. It appears as a request while idle, `busy` high after a completion, a pulse held for two cycles, or two completion pulses high together. A wrong latched index or base appears at the request address in the first request cycle. A wrong link flag or return address appears at the single completion pulse. A stale reserved-mode flag appears on the next issue as an unexpected `illegal` pulse, or as a missing one.

// File: rtl/tbljmp_pkg.sv
package tbljmp_pkg;
    localparam int MODE_W = 6;
    localparam int IDX_W  = 8;
    localparam int LINK_MIN = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } tj_state_e;

    typedef enum logic [1:0] {
        END_JUMP  = 2'd0,
        END_FAULT = 2'd1,
        END_ILL   = 2'd2
    } tj_end_e;
endpackage

// File: rtl/tbljmp_csr.sv
module tbljmp_csr
    import tbljmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_data,
    output logic            mode_bad
);
    localparam int BASE_W = XLEN - MODE_W;

    logic [BASE_W-1:0] base_q;
    logic              bad_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            bad_q  <= 1'b0;
        end else if (wr_en) begin
            base_q <= wr_data[XLEN-1:MODE_W];
            bad_q  <= |wr_data[MODE_W-1:0];
        end
    end

    assign rd_data  = {base_q, {MODE_W{1'b0}}};
    assign mode_bad = bad_q;
endmodule

// File: rtl/tbljmp_addr.sv
module tbljmp_addr
    import tbljmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [15:0]     insn,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] table_base,
    output logic [XLEN-1:0] slot_addr,
    output logic [XLEN-1:0] ret_addr,
    output logic            is_link
);
    localparam int SHIFT = (XLEN == 64) ? 3 : 2;

    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    assign idx         = insn[9:2];
    assign unused_bits = ^{insn[15:10], insn[1:0]};
    assign slot_addr   = table_base + ({{(XLEN-IDX_W){1'b0}}, idx} << SHIFT);
    assign ret_addr    = pc + XLEN'(2);
    assign is_link     = (idx >= IDX_W'(LINK_MIN));
endmodule

// File: rtl/tbljmp_ctrl.sv
module tbljmp_ctrl
    import tbljmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            issue_bad,
    input  logic            issue_link,
    input  logic [XLEN-1:0] issue_addr,
    input  logic [XLEN-1:0] issue_ret,
    output logic            busy,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            fault,
    output logic            illegal
);
    tj_state_e       state_q, state_d;
    tj_end_e         end_q;
    logic            link_q;
    logic [XLEN-1:0] addr_q, ret_q, tgt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (issue_valid) state_d = issue_bad ? ST_DONE : ST_REQ;
            ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q  <= END_JUMP;
            link_q <= 1'b0;
            addr_q <= '0;
            ret_q  <= '0;
            tgt_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && issue_valid) begin
                end_q  <= issue_bad ? END_ILL : END_JUMP;
                link_q <= issue_link;
                addr_q <= issue_addr;
                ret_q  <= issue_ret;
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                tgt_q <= mem_rsp_data;
                if (mem_rsp_err) end_q <= END_FAULT;
            end
        end
    end

    always_comb begin
        mem_req_valid  = 1'b0;
        redirect_valid = 1'b0;
        link_we        = 1'b0;
        fault          = 1'b0;
        illegal        = 1'b0;
        unique case (state_q)
            ST_REQ:  mem_req_valid = 1'b1;
            ST_DONE: begin
                redirect_valid = (end_q == END_JUMP);
                link_we        = (end_q == END_JUMP) && link_q;
                fault          = (end_q == END_FAULT);
                illegal        = (end_q == END_ILL);
            end
            default: ;
        endcase
    end

    assign busy         = (state_q != ST_IDLE);
    assign mem_req_addr = addr_q;
    assign redirect_pc  = tgt_q;
    assign link_data    = ret_q;

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);
    p_one_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redirect_valid, fault, illegal}));
    p_end_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid || fault || illegal |=> !busy && !redirect_valid && !fault && !illegal);
    p_link_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> redirect_valid);
    p_ill_noreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(!mem_req_valid));
endmodule

// File: rtl/tbljmp_unit.sv
module tbljmp_unit
    import tbljmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr_en,
    input  logic [XLEN-1:0] csr_wr_data,
    output logic [XLEN-1:0] csr_rd_data,
    input  logic            issue_valid,
    input  logic [15:0]     issue_insn,
    input  logic [XLEN-1:0] issue_pc,
    output logic            busy,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            fault,
    output logic            illegal
);
    logic            mode_bad;
    logic            is_link;
    logic [XLEN-1:0] slot_addr, ret_addr;

    tbljmp_csr #(.XLEN(XLEN)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_wr_en),
        .wr_data  (csr_wr_data),
        .rd_data  (csr_rd_data),
        .mode_bad (mode_bad)
    );

    tbljmp_addr #(.XLEN(XLEN)) u_addr (
        .insn       (issue_insn),
        .pc         (issue_pc),
        .table_base (csr_rd_data),
        .slot_addr  (slot_addr),
        .ret_addr   (ret_addr),
        .is_link    (is_link)
    );

    tbljmp_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_valid    (issue_valid),
        .issue_bad      (mode_bad),
        .issue_link     (is_link),
        .issue_addr     (slot_addr),
        .issue_ret      (ret_addr),
        .busy           (busy),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .mem_rsp_err    (mem_rsp_err),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .link_we        (link_we),
        .link_data      (link_data),
        .fault          (fault),
        .illegal        (illegal)
    );
endmodule

// File: tb/tb_tbljmp_unit.sv
module tb_tbljmp_unit;
    localparam int XLEN = 32;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_wr_en = 1'b0;
    logic [XLEN-1:0] csr_wr_data = '0;
    logic [XLEN-1:0] csr_rd_data;
    logic            issue_valid = 1'b0;
    logic [15:0]     issue_insn = '0;
    logic [XLEN-1:0] issue_pc = '0;
    logic            busy;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic [XLEN-1:0] mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [XLEN-1:0] mem_rsp_data = '0;
    logic            mem_rsp_err = 1'b0;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic            link_we;
    logic [XLEN-1:0] link_data;
    logic            fault;
    logic            illegal;

    int checks = 0;
    int errors = 0;
    logic [XLEN-1:0] base_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbljmp_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n),
        .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
        .issue_valid(issue_valid), .issue_insn(issue_insn), .issue_pc(issue_pc),
        .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .link_we(link_we), .link_data(link_data),
        .fault(fault), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] table_word(input logic [XLEN-1:0] a);
        return (a * 3) ^ 32'h8000_1100;
    endfunction

    task automatic csr_write(input logic [XLEN-1:0] v);
        @(negedge clk);
        csr_wr_en = 1'b1;
        csr_wr_data = v;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check(!busy && !mem_req_valid && !redirect_valid && !link_we && !fault && !illegal,
              "R1 idle outputs", {busy, mem_req_valid, redirect_valid, link_we, fault, illegal}, 0);
        check(csr_rd_data == 0, "R1 csr", csr_rd_data, 0);
    endtask

    task automatic t_csr();
        csr_write(32'h0000_80FF);
        check(csr_rd_data == 32'h0000_80C0, "R2 mode masked", csr_rd_data, 32'h0000_80C0);
        csr_write(32'h0000_8000);
        check(csr_rd_data == 32'h0000_8000, "R2 legal write", csr_rd_data, 32'h0000_8000);
        base_exp = 32'h0000_8000;
    endtask

    // one jump: drive issue, play memory, check completion
    task automatic do_jump(input logic [15:0] insn, input logic [XLEN-1:0] pc, input bit err,
                           input int delay, input bit poke, input string tag);
        logic [7:0]      idx;
        logic [XLEN-1:0] ea;
        bit              lk;
        idx = insn[9:2];
        ea  = base_exp + (XLEN'(idx) << 2);
        lk  = (idx >= 8'd32);
        @(negedge clk);
        issue_valid = 1'b1; issue_insn = insn; issue_pc = pc;
        @(negedge clk);
        issue_valid = 1'b0; issue_insn = ~insn; issue_pc = ~pc;
        check(busy && mem_req_valid, {"R9 request after issue ", tag}, {busy, mem_req_valid}, 2'b11);
        check(mem_req_addr == ea, {"R5 address ", tag}, mem_req_addr, ea);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == ea, {"R9 request held ", tag}, mem_req_addr, ea);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(busy && !mem_req_valid, {"R9 waiting ", tag}, {busy, mem_req_valid}, 2'b10);
        if (poke) begin
            issue_valid = 1'b1; issue_insn = 16'h0402; issue_pc = 32'h9000;
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = table_word(ea); mem_rsp_err = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; issue_valid = 1'b0;
        if (err) begin
            check(fault && !redirect_valid && !link_we && !illegal, {"R8 fault ", tag},
                  {fault, redirect_valid, link_we, illegal}, 4'b1000);
        end else begin
            check(redirect_valid && !fault && !illegal, {"R6 redirect ", tag},
                  {redirect_valid, fault, illegal}, 3'b100);
            check(redirect_pc == table_word(ea), {"R6 target ", tag}, redirect_pc, table_word(ea));
            check(link_we == lk, {"R7 link select ", tag}, link_we, lk);
            if (lk) check(link_data == pc + 2, {"R7 return address ", tag}, link_data, pc + 2);
        end
        check(busy, {"R9 busy at completion ", tag}, busy, 1);
        @(negedge clk);
        check(!busy && !redirect_valid && !fault && !illegal && !link_we, {"R10 single pulse ", tag},
              {busy, redirect_valid, fault, illegal, link_we}, 0);
        if (poke) begin
            @(negedge clk);
            check(!mem_req_valid && !busy, "R9 issue while busy ignored", {mem_req_valid, busy}, 0);
        end
    endtask

    task automatic t_reserved();
        csr_write(32'h0000_4005);
        base_exp = 32'h0000_4000;
        check(csr_rd_data == 32'h0000_4000, "R2 reserved mode reads zero", csr_rd_data, 32'h0000_4000);
        @(negedge clk);
        issue_valid = 1'b1; issue_insn = 16'hA012; issue_pc = 32'h100;
        @(negedge clk);
        issue_valid = 1'b0;
        check(illegal && !mem_req_valid && !redirect_valid && !link_we && !fault, "R3 illegal",
              {illegal, mem_req_valid, redirect_valid, link_we, fault}, 5'b10000);
        @(negedge clk);
        check(!illegal && !busy && !mem_req_valid, "R3 R10 illegal pulse ends",
              {illegal, busy, mem_req_valid}, 0);
        csr_write(32'h0000_4000);
        do_jump(16'hA012, 32'h100, 1'b0, 0, 1'b0, "R3 cleared");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_csr();
        do_jump(16'h0014, 32'h0000_2000, 1'b0, 0, 1'b0, "R4 idx5");
        do_jump(16'hFC17, 32'h0000_2000, 1'b0, 0, 1'b0, "R4 idx5 other bits");
        do_jump(16'h007C, 32'h0000_2010, 1'b0, 0, 1'b0, "R6 idx31");
        do_jump(16'h0080, 32'h0000_2020, 1'b0, 0, 1'b0, "R7 idx32");
        do_jump(16'h03FE, 32'h0000_3FFE, 1'b0, 2, 1'b0, "R7 idx255");
        do_jump(16'h0104, 32'h0000_2100, 1'b0, 3, 1'b0, "R9 slow ready");
        do_jump(16'h0088, 32'h0000_2200, 1'b1, 0, 1'b0, "R8 error");
        do_jump(16'h0028, 32'h0000_2300, 1'b0, 0, 1'b1, "R9 poke");
        t_reserved();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule